// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serialises words onto an asynchronous serial line. A host writes a word into a one-entry holding register. The word moves into a shift register when three things are true at a bit boundary: the shift register is free, transmission is enabled, and the clear-to-send input is low. Because the holding register empties at that hand-off, the host can queue the next word while the current frame is still on the line. When data is waiting, frames go out back to back with no idle gap between them.

A mode word sets the frame format: 7, 8 or 9 data bits, one or two stop bits, and an optional parity bit with odd or even sense. The mode word also chooses the timing source, either a prescaled internal clock picked by a two-bit source selector or an external clock input. A programmable divider stretches the chosen source into the bit period. Two flags report progress: one shows that the holding register can take a word, the other that the line has gone idle after the last stop bit.

Top module: `async_tx_engine`

## Requirements
- R1: After reset `txd` is high, `buf_empty` is 1 and `shift_empty` is 1. The line stays high whenever no frame is being sent.
- R2: A frame is sent in this order: a low start bit, the data bits least significant first, the parity bit if parity is enabled, then the high stop bit or bits.
- R3: `mode_reg[2:0]` sets the data length: 3'b100 gives 7 bits, 3'b101 gives 8 bits and 3'b110 gives 9 bits. With any other value no frame starts, and a word already written stays held (`buf_empty` stays 0).
- R4: `mode_reg[6]`=1 adds a parity bit after the data. `mode_reg[5]`=1 selects odd parity, where data plus parity hold an odd number of ones. `mode_reg[5]`=0 selects even parity, where that total is even.
- R5: `mode_reg[4]`=0 sends one stop bit and `mode_reg[4]`=1 sends two.
- R6: Each bit lasts (`rate_div`+1)×16 ticks of the selected source. With `mode_reg[3]`=1 the source is each rising edge of `ext_clk`. With `mode_reg[3]`=0 the source is `clk` divided by 1, 8, 32 or 256 for `src_sel` = 0, 1, 2 or 3.
- R7: `buf_empty` returns to 1 when the word moves into the shift register. A second word written then is sent directly after the first frame.
- R8: `shift_empty` is 0 from the start of a frame until the last stop bit of the last queued frame has ended, and 1 after that.
- R9: A write while `buf_empty` is 0 is ignored. The held word is not changed.
- R10: Dropping `tx_en` lets the current frame finish. No further frame starts, and a waiting word stays held until `tx_en` returns.
- R11: A frame starts only at a bit boundary where `cts_n` is low. If `cts_n` rises during a frame, that frame still completes, but the next frame waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe into the holding register |
| wr_data | input | 9 | Word to send (upper bits unused for shorter lengths) |
| mode_reg | input | 7 | Frame format and clock source mode word |
| src_sel | input | 2 | Internal source prescale select |
| rate_div | input | BRG_W (8) | Bit-rate divider value n |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear to send, active low |
| ext_clk | input | 1 | External timing source |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register can accept a word |
| shift_empty | output | 1 | No frame in progress or pending hand-off |

## Verification
A scoreboard rebuilds every expected frame from the word and the mode bits, then samples the line at bit centres. A wrong bit order, a parity of the wrong sense, a missing stop bit or a wrong divider ratio therefore shows up as a mismatched frame. Directed cases hold a word back with `cts_n` high, with `tx_en` low and with an illegal length code. A design that ignores these gates sends a frame the scoreboard never expected, and a design that cuts a frame short on the gate change produces a corrupted frame. A write into a full holding register must not overwrite the held word; if it does, the wrong word appears on the line. A second word queued during a frame must follow immediately, and `shift_empty` must stay low across both frames.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
    localparam int MAX_DATA = 9;
    localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        LEN_7 = 3'b100,
        LEN_8 = 3'b101,
        LEN_9 = 3'b110
    } len_code_e;

    function automatic logic len_code_ok(input logic [2:0] c);
        return (c == LEN_7) || (c == LEN_8) || (c == LEN_9);
    endfunction

    function automatic int len_of(input logic [2:0] c);
        case (c)
            LEN_7:   return 7;
            LEN_8:   return 8;
            default: return 9;
        endcase
    endfunction
endpackage

// File: rtl/txe_rate_gen.sv
module txe_rate_gen #(
    parameter int BRG_W = 8,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic [1:0]       src_sel,
    input  logic [BRG_W-1:0] rate_div,
    input  logic             ext_clk,
    output logic             bit_tick
);
    localparam int SUB_W = 4;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [BRG_W-1:0] div;
        logic [SUB_W-1:0] sub;
        logic [2:0]       ext_s;
        logic             tick;
    } rg_t;

    rg_t q, d;
    logic [3:0] int_tick;
    logic       src_tick;

    for (genvar g = 0; g < 4; g++) begin : g_pre
        localparam int SH = (g == 0) ? 0 : (g == 1) ? 3 : (g == 2) ? 5 : PRE_W;
        if (SH == 0) begin : g_full
            assign int_tick[g] = 1'b1;
        end else begin : g_part
            assign int_tick[g] = &q.pre[SH-1:0];
        end
    end

    assign src_tick = ext_sel ? (q.ext_s[1] & ~q.ext_s[2]) : int_tick[src_sel];

    always_comb begin
        d       = q;
        d.pre   = q.pre + 1'b1;
        d.ext_s = {q.ext_s[1:0], ext_clk};
        d.tick  = 1'b0;
        if (src_tick) begin
            if (q.div == '0) begin
                d.div = rate_div;
                d.sub = q.sub + 1'b1;
                if (q.sub == '1) d.tick = 1'b1;
            end else begin
                d.div = q.div - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_tick = q.tick;

    a_r6_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
endmodule

// File: rtl/txe_frame_pack.sv
module txe_frame_pack
    import async_tx_pkg::*;
(
    input  logic [MAX_DATA-1:0] data,
    input  logic [6:0]          mode,
    output logic [FRAME_W-1:0]  frame,
    output logic [CNT_W-1:0]    nbits
);
    int   len;
    int   pos;
    logic par;

    always_comb begin
        len   = len_of(mode[2:0]);
        frame = '1;
        frame[0] = 1'b0;
        par   = mode[5];
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < len) begin
                frame[1+i] = data[i];
                par = par ^ data[i];
            end
        end
        pos = 1 + len;
        if (mode[6]) begin
            frame[pos] = par;
            pos = pos + 1;
        end
        pos   = pos + (mode[4] ? 2 : 1);
        nbits = CNT_W'(pos);
    end
endmodule

// File: rtl/txe_shifter.sv
module txe_shifter
    import async_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    output logic               free_at_tick,
    output logic               txd,
    output logic               busy
);
    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   left;
        logic               busy;
        logic               txd;
    } sh_t;

    sh_t q, d;
    logic [FRAME_W-1:0] nxt_sh;

    assign free_at_tick = !q.busy || (q.left == '0);
    assign nxt_sh       = {1'b1, q.sh[FRAME_W-1:1]};

    always_comb begin
        d = q;
        if (load) begin
            d.sh   = frame;
            d.left = nbits - 1'b1;
            d.busy = 1'b1;
            d.txd  = frame[0];
        end else if (bit_tick && q.busy) begin
            if (q.left == '0) begin
                d.busy = 1'b0;
                d.txd  = 1'b1;
            end else begin
                d.sh   = nxt_sh;
                d.left = q.left - 1'b1;
                d.txd  = nxt_sh[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.txd  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd  = q.txd;
    assign busy = q.busy;

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> busy);
endmodule

// File: rtl/async_tx_engine.sv
module async_tx_engine
    import async_tx_pkg::*;
#(
    parameter int BRG_W = 8,
    parameter int PRE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [MAX_DATA-1:0] wr_data,
    input  logic [6:0]          mode_reg,
    input  logic [1:0]          src_sel,
    input  logic [BRG_W-1:0]    rate_div,
    input  logic                tx_en,
    input  logic                cts_n,
    input  logic                ext_clk,
    output logic                txd,
    output logic                buf_empty,
    output logic                shift_empty
);
    typedef struct packed {
        logic [MAX_DATA-1:0] hold;
        logic                full;
    } hb_t;

    hb_t q, d;
    logic               bit_tick;
    logic               free_at_tick;
    logic               busy;
    logic               fmt_ok;
    logic               load;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;

    txe_rate_gen #(.BRG_W(BRG_W), .PRE_W(PRE_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_sel  (mode_reg[3]),
        .src_sel  (src_sel),
        .rate_div (rate_div),
        .ext_clk  (ext_clk),
        .bit_tick (bit_tick)
    );

    txe_frame_pack u_pack (
        .data  (q.hold),
        .mode  (mode_reg),
        .frame (frame),
        .nbits (nbits)
    );

    assign fmt_ok = len_code_ok(mode_reg[2:0]);
    assign load   = bit_tick && free_at_tick && q.full && tx_en && !cts_n && fmt_ok;

    always_comb begin
        d = q;
        if (load) begin
            d.full = 1'b0;
        end else if (wr_en && !q.full) begin
            d.full = 1'b1;
            d.hold = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    txe_shifter u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .load         (load),
        .frame        (frame),
        .nbits        (nbits),
        .free_at_tick (free_at_tick),
        .txd          (txd),
        .busy         (busy)
    );

    assign buf_empty   = !q.full;
    assign shift_empty = !busy;

    a_r7_empty_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> buf_empty);
    a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_empty && wr_en && !load) |=> (!buf_empty && q.hold == $past(q.hold)));
    a_r11_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> ($past(tx_en) && !$past(cts_n)));
    a_r3_start_legal_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> len_code_ok($past(mode_reg[2:0])));
endmodule

// File: tb/sim_async_tx_engine.sv
module sim_async_tx_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [6:0] mode_reg = 7'b0000101;
    logic [1:0] src_sel = 2'd0;
    logic [7:0] rate_div = 8'd0;
    logic       tx_en = 1'b1;
    logic       cts_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       txd, buf_empty, shift_empty;

    typedef struct {
        logic [12:0] bits;
        int          n;
        int          bp;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cur_bp = 16;

    always #4 clk = ~clk;

    async_tx_engine u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode_reg(mode_reg), .src_sel(src_sel), .rate_div(rate_div),
        .tx_en(tx_en), .cts_n(cts_n), .ext_clk(ext_clk),
        .txd(txd), .buf_empty(buf_empty), .shift_empty(shift_empty)
    );

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            ext_clk = ~ext_clk;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic exp_t build(input logic [8:0] d, input logic [6:0] m, input string tag);
        exp_t e;
        int len, ones;
        len = (m[2:0] == 3'b100) ? 7 : (m[2:0] == 3'b101) ? 8 : 9;
        e.bits = '1;
        e.bits[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < len; i++) begin
            e.bits[1+i] = d[i];
            ones += int'(d[i]);
        end
        e.n = 1 + len;
        if (m[6]) begin
            e.bits[e.n] = m[5] ? ~ones[0] : ones[0];
            e.n++;
        end
        e.n += m[4] ? 2 : 1;
        e.bp = cur_bp;
        e.tag = tag;
        return e;
    endfunction

    // Driver: writes a word; pushes the expected frame when it will be sent
    task automatic send(input logic [8:0] d, input bit push, input string tag);
        @(negedge clk);
        if (push) exp_q.push_back(build(d, mode_reg, tag));
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || !shift_empty || !buf_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: samples each bit at its centre and compares against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R3/R9/R10/R11 unexpected frame actual=start expected=idle");
                    repeat (13 * cur_bp) @(negedge clk);
                end else begin
                    exp_t e;
                    logic [12:0] got;
                    e = exp_q[0];
                    got = '1;
                    repeat (e.bp / 2 - 1) @(negedge clk);
                    got[0] = txd;
                    for (int i = 1; i < e.n; i++) begin
                        repeat (e.bp) @(negedge clk);
                        got[i] = txd;
                    end
                    void'(exp_q.pop_front());
                    chk(e.tag, 32'(got), 32'(e.bits));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(negedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", 32'(txd), 32'd1);
        chk("R1 buf_empty", 32'(buf_empty), 32'd1);
        chk("R1 shift_empty", 32'(shift_empty), 32'd1);

        // R2 R3: 8-bit, no parity, one stop
        mode_reg = 7'b0000101;
        send(9'h0A5, 1, "R2 R3 8-bit frame");
        wait_idle();
        // R3 R4: 7-bit, even parity
        mode_reg = 7'b1000100;
        send(9'h05B, 1, "R3 R4 7-bit even parity");
        wait_idle();
        // R4 R5: 9-bit, odd parity, two stops
        mode_reg = 7'b1110110;
        send(9'h1C3, 1, "R4 R5 9-bit odd parity two stops");
        wait_idle();
        // R4 odd parity with odd data ones
        mode_reg = 7'b1100101;
        send(9'h007, 1, "R4 odd parity 8-bit");
        wait_idle();

        // R7 R8: back-to-back via double buffer
        mode_reg = 7'b0000101;
        send(9'h03C, 1, "R7 first");
        while (!buf_empty) @(negedge clk);
        chk("R8 shift_empty low in frame", 32'(shift_empty), 32'd0);
        send(9'h0C3, 1, "R7 second");
        chk("R7 buf_empty after second write", 32'(buf_empty), 32'd0);
        while (exp_q.size() == 2) @(negedge clk);
        @(negedge clk);
        chk("R8 shift_empty between queued frames", 32'(shift_empty), 32'd0);
        wait_idle();
        chk("R8 shift_empty after last stop", 32'(shift_empty), 32'd1);

        // R11 R9: held by CTS, second write ignored
        cts_n = 1'b1;
        send(9'h011, 1, "R11 R9 held word");
        repeat (100) @(negedge clk);
        chk("R11 buf held", 32'(buf_empty), 32'd0);
        chk("R11 line idle", 32'(txd), 32'd1);
        send(9'h022, 0, "R9");
        cts_n = 1'b0;
        wait_idle();

        // R11: CTS rising mid-frame does not cut the frame
        send(9'h055, 1, "R11 mid-frame cts");
        while (shift_empty) @(negedge clk);
        repeat (3 * cur_bp) @(negedge clk);
        cts_n = 1'b1;
        send(9'h066, 0, "R11");
        while (!shift_empty) @(negedge clk);
        repeat (3 * cur_bp) @(negedge clk);
        chk("R11 next frame waits", 32'(buf_empty), 32'd0);
        exp_q.push_back(build(9'h066, mode_reg, "R11 released word"));
        cts_n = 1'b0;
        wait_idle();

        // R10: tx_en drop finishes frame, holds next
        send(9'h00F, 1, "R10 frame completes");
        while (shift_empty) @(negedge clk);
        send(9'h0F0, 0, "R10");
        repeat (2 * cur_bp) @(negedge clk);
        tx_en = 1'b0;
        while (!shift_empty) @(negedge clk);
        repeat (3 * cur_bp) @(negedge clk);
        chk("R10 word held", 32'(buf_empty), 32'd0);
        chk("R10 line idle", 32'(txd), 32'd1);
        exp_q.push_back(build(9'h0F0, mode_reg, "R10 resumed word"));
        tx_en = 1'b1;
        wait_idle();

        // R3: illegal length code holds the word
        mode_reg = 7'b0000000;
        send(9'h077, 0, "R3");
        repeat (60) @(negedge clk);
        chk("R3 illegal code holds", 32'(buf_empty), 32'd0);
        chk("R3 illegal code line idle", 32'(txd), 32'd1);
        mode_reg = 7'b0000101;
        exp_q.push_back(build(9'h077, mode_reg, "R3 legal code resumes"));
        wait_idle();

        // R6: internal prescale /8, n=2
        src_sel = 2'd1;
        rate_div = 8'd2;
        cur_bp = 16 * 3 * 8;
        send(9'h0B2, 1, "R6 prescale 8 divider 3");
        wait_idle();
        // R6: external source, period 6 clocks, n=1
        src_sel = 2'd0;
        rate_div = 8'd1;
        mode_reg = 7'b1011101;
        cur_bp = 16 * 2 * 6;
        send(9'h04D, 1, "R6 external source");
        wait_idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule